// File: doc/BRIEF.md
# Floating-Point Status and Exception Controller

This block keeps the floating-point status and control word next to an arithmetic unit. The arithmetic unit computes nothing here. It reports, at the end of each operation, which of five exception conditions occurred: invalid, divide-by-zero, overflow, underflow and inexact. The controller records these conditions in a sticky-free flag field and accumulates them into a cause field. It raises an exception request whenever a recorded cause meets its enable bit.

Software loads the word through a write port, and bits that have no meaning are dropped. Two control outputs come straight from the stored word. One selects truncation or round-to-nearest-even for the datapath. The other turns on flush-to-zero handling of denormals. A compare that finishes unordered updates the word in the same way as an arithmetic operation. A compare that finishes ordered leaves the word alone.

Top module: `fpsr_ctrl`

## Requirements
- R1: After reset the status word reads 0, the exception request is low and the vector output is 0.
- R2: A write stores `wr_data` masked so that only bit 18 and bits 16:0 can be set. Every other bit reads as 0. The new value is visible in the cycle after the write.
- R3: `rnd_trunc_o` is 1 exactly when status bits 1:0 hold 01 (truncate). The encodings 00, 10 and 11 give 0 (round-to-nearest-even).
- R4: `flush_o` follows status bit 18.
- R5: On `op_done` without a write, status bits 6:2 are replaced by `op_flags`. `op_flags` bit 0 is inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero and bit 4 invalid. Status bit 2 receives `op_flags` bit 0, and the other bits follow in the same order. The new value is visible one cycle later.
- R6: When the reported flags are non-zero, they are OR-ed into the cause field at bits 16:12, in the same bit order, and existing cause bits stay set. When the reported flags are all zero, the cause field is unchanged.
- R7: `exc_req_o` pulses for exactly one cycle, the cycle after the update. It pulses only when the reported flags are non-zero and some cause bit after the update has its enable bit (bits 11:7, same order) set. `exc_vec_o` is 0x120 during the pulse and 0 otherwise.
- R8: A compare completion with `cmp_unord` = 1 performs the same update as R5 to R7. A compare completion with `cmp_unord` = 0 leaves the status word unchanged.
- R9: When a write and a completion occur in the same cycle, only the write takes effect and no exception request is raised.
- R10: Updates never change the enable field, the rounding bits or bit 18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write the status word |
| wr_data | input | 32 | Value to write |
| op_done | input | 1 | Arithmetic operation completed |
| cmp_done | input | 1 | Compare completed |
| cmp_unord | input | 1 | Completed compare was unordered |
| op_flags | input | 5 | Reported conditions: bit 0 inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero, bit 4 invalid |
| fpsr_o | output | 32 | Stored status word |
| rnd_trunc_o | output | 1 | 1 selects truncation, 0 round-to-nearest-even |
| flush_o | output | 1 | Flush-to-zero of denormals |
| exc_req_o | output | 1 | Exception request pulse |
| exc_vec_o | output | 12 | Vector offset during the pulse, else 0 |

## Verification
The bench targets an operation that reports no conditions while an old cause bit still meets its enable. A design that tested the stale cause would raise a false exception there. The bench also covers a write colliding with a completion, where a wrong priority would merge flags into the written value or raise a request. Ordered compares are checked to leave the word intact. Every rounding encoding is walked, so that a decoder treating any non-zero mode as truncation is caught. Random traffic then checks that cause bits only accumulate and that each request lasts exactly one cycle.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;

    localparam int CSR_W     = 32;
    localparam int FLAG_N    = 5;
    localparam int RM_LSB    = 0;
    localparam int RM_W      = 2;
    localparam int FLAG_LSB  = 2;
    localparam int ENA_LSB   = FLAG_LSB + FLAG_N;
    localparam int CAUSE_LSB = ENA_LSB + FLAG_N;
    localparam int DN_BIT    = 18;

    localparam logic [RM_W-1:0] RM_TRUNC = 2'b01;

    typedef enum logic [1:0] {
        SRC_IDLE,
        SRC_WRITE,
        SRC_UPDATE
    } src_e;

    typedef struct packed {
        logic [CSR_W-1:0] csr;
        logic             exc;
    } state_t;

    function automatic logic [CSR_W-1:0] build_wmask();
        logic [CSR_W-1:0] m;
        m = '0;
        for (int i = 0; i < RM_W; i++)   m[RM_LSB + i]    = 1'b1;
        for (int i = 0; i < FLAG_N; i++) begin
            m[FLAG_LSB + i]  = 1'b1;
            m[ENA_LSB + i]   = 1'b1;
            m[CAUSE_LSB + i] = 1'b1;
        end
        m[DN_BIT] = 1'b1;
        return m;
    endfunction

    localparam logic [CSR_W-1:0] WMASK = build_wmask();

endpackage

// File: rtl/fpsr_flag_merge.sv
module fpsr_flag_merge
    import fpsr_pkg::*;
(
    input  logic [CSR_W-1:0]  csr_i,
    input  logic [FLAG_N-1:0] flags_i,
    output logic [CSR_W-1:0]  csr_o,
    output logic              raise_o
);

    logic             any_flag;
    logic [FLAG_N-1:0] hit;

    assign any_flag = |flags_i;

    always_comb begin
        csr_o = csr_i;
        csr_o[FLAG_LSB +: FLAG_N] = flags_i;
        if (any_flag) begin
            csr_o[CAUSE_LSB +: FLAG_N] = csr_i[CAUSE_LSB +: FLAG_N] | flags_i;
        end
    end

    // one comparator per condition: cause meets enable in the same lane
    for (genvar g = 0; g < FLAG_N; g++) begin : g_lane
        assign hit[g] = csr_o[CAUSE_LSB + g] & csr_o[ENA_LSB + g];
    end

    assign raise_o = any_flag & (|hit);

endmodule

// File: rtl/fpsr_mode_decode.sv
module fpsr_mode_decode
    import fpsr_pkg::*;
(
    input  logic [RM_W-1:0] rm_i,
    input  logic            dn_i,
    output logic            trunc_o,
    output logic            flush_o
);

    always_comb begin
        trunc_o = (rm_i == RM_TRUNC);
        flush_o = dn_i;
    end

endmodule

// File: rtl/fpsr_ctrl.sv
module fpsr_ctrl
    import fpsr_pkg::*;
#(
    parameter int                VEC_W   = 12,
    parameter logic [VEC_W-1:0]  EXC_VEC = 12'h120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CSR_W-1:0]  wr_data,
    input  logic              op_done,
    input  logic              cmp_done,
    input  logic              cmp_unord,
    input  logic [FLAG_N-1:0] op_flags,
    output logic [CSR_W-1:0]  fpsr_o,
    output logic              rnd_trunc_o,
    output logic              flush_o,
    output logic              exc_req_o,
    output logic [VEC_W-1:0]  exc_vec_o
);

    state_t           st_d, st_q;
    src_e             src;
    logic [CSR_W-1:0] merged;
    logic             raise;

    fpsr_flag_merge u_merge (
        .csr_i   (st_q.csr),
        .flags_i (op_flags),
        .csr_o   (merged),
        .raise_o (raise)
    );

    always_comb begin
        if (wr_en)                                src = SRC_WRITE;
        else if (op_done || (cmp_done && cmp_unord)) src = SRC_UPDATE;
        else                                      src = SRC_IDLE;
    end

    always_comb begin
        st_d     = st_q;
        st_d.exc = 1'b0;
        case (src)
            SRC_WRITE:  st_d.csr = wr_data & WMASK;
            SRC_UPDATE: begin
                st_d.csr = merged;
                st_d.exc = raise;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    fpsr_mode_decode u_mode (
        .rm_i    (st_q.csr[RM_LSB +: RM_W]),
        .dn_i    (st_q.csr[DN_BIT]),
        .trunc_o (rnd_trunc_o),
        .flush_o (flush_o)
    );

    assign fpsr_o    = st_q.csr;
    assign exc_req_o = st_q.exc;
    assign exc_vec_o = st_q.exc ? EXC_VEC : '0;

endmodule

// File: rtl/fpsr_ctrl_chk.sv
module fpsr_ctrl_chk
    import fpsr_pkg::*;
#(
    parameter int               VEC_W   = 12,
    parameter logic [VEC_W-1:0] EXC_VEC = 12'h120
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [CSR_W-1:0] wr_data,
    input logic             op_done,
    input logic             cmp_done,
    input logic             cmp_unord,
    input logic [CSR_W-1:0] fpsr_o,
    input logic             exc_req_o,
    input logic [VEC_W-1:0] exc_vec_o
);

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fpsr_o & ~WMASK) == '0);

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (fpsr_o == ($past(wr_data) & WMASK)) && !exc_req_o);

    assert_req_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_o |-> $past(op_done || (cmp_done && cmp_unord)) && !$past(wr_en));

    assert_vec_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_o |-> exc_vec_o == EXC_VEC);

    assert_vec_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_req_o |-> exc_vec_o == '0);

    assert_ordered_cmp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_done && !cmp_unord && !op_done && !wr_en) |=> $stable(fpsr_o));

    assert_cause_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !wr_en) |=>
            ((fpsr_o[CAUSE_LSB +: FLAG_N] & $past(fpsr_o[CAUSE_LSB +: FLAG_N]))
             == $past(fpsr_o[CAUSE_LSB +: FLAG_N])));

    assert_ctrl_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !wr_en) |=> (fpsr_o[ENA_LSB +: FLAG_N] == $past(fpsr_o[ENA_LSB +: FLAG_N]))
                                && (fpsr_o[DN_BIT] == $past(fpsr_o[DN_BIT])));

endmodule

bind fpsr_ctrl fpsr_ctrl_chk #(.VEC_W(VEC_W), .EXC_VEC(EXC_VEC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .op_done   (op_done),
    .cmp_done  (cmp_done),
    .cmp_unord (cmp_unord),
    .fpsr_o    (fpsr_o),
    .exc_req_o (exc_req_o),
    .exc_vec_o (exc_vec_o)
);

// File: tb/fpsr_ctrl_test.sv
module fpsr_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        op_done = 1'b0;
    logic        cmp_done = 1'b0;
    logic        cmp_unord = 1'b0;
    logic [4:0]  op_flags = '0;
    logic [31:0] fpsr_o;
    logic        rnd_trunc_o, flush_o, exc_req_o;
    logic [11:0] exc_vec_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] model = '0;
    logic        model_exc = 1'b0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    fpsr_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .op_done(op_done), .cmp_done(cmp_done), .cmp_unord(cmp_unord),
        .op_flags(op_flags), .fpsr_o(fpsr_o), .rnd_trunc_o(rnd_trunc_o),
        .flush_o(flush_o), .exc_req_o(exc_req_o), .exc_vec_o(exc_vec_o)
    );

    function automatic logic [31:0] next_word(logic [31:0] cur, logic w, logic [31:0] wd,
                                              logic upd, logic [4:0] fl);
        logic [31:0] r;
        r = cur;
        if (w) r = wd & 32'h0005_FFFF;
        else if (upd) begin
            r[6:2] = fl;
            if (fl != 0) r[16:12] = cur[16:12] | fl;
        end
        return r;
    endfunction

    function automatic logic next_exc(logic w, logic upd, logic [4:0] fl, logic [31:0] nw);
        return !w && upd && (fl != 0) && ((nw[16:12] & nw[11:7]) != 0);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        chk(req, fpsr_o, model);
        chk("R3 rounding select", {31'd0, rnd_trunc_o}, {31'd0, model[1:0] == 2'b01});
        chk("R4 flush control", {31'd0, flush_o}, {31'd0, model[18]});
        chk("R7 request", {31'd0, exc_req_o}, {31'd0, model_exc});
        chk("R7 vector", {20'd0, exc_vec_o}, model_exc ? 32'h120 : 32'h0);
    endtask

    // drive one cycle at negedge, sample at the following negedge
    task automatic step(string req, logic w, logic [31:0] wd, logic od,
                        logic cd, logic cu, logic [4:0] fl);
        logic upd;
        logic [31:0] nw;
        wr_en = w; wr_data = wd; op_done = od; cmp_done = cd; cmp_unord = cu; op_flags = fl;
        upd = od || (cd && cu);
        nw = next_word(model, w, wd, upd, fl);
        model_exc = next_exc(w, upd, fl, nw);
        model = nw;
        @(negedge clk);
        wr_en = 1'b0; op_done = 1'b0; cmp_done = 1'b0; cmp_unord = 1'b0;
        check_all(req);
    endtask

    task automatic idle(string req);
        step(req, 1'b0, '0, 1'b0, 1'b0, 1'b0, 5'd0);
    endtask

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset state");

        // R2 write mask
        step("R2 masked write", 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 5'd0);
        step("R2 masked write", 1'b1, 32'hFFFA_0000, 1'b0, 1'b0, 1'b0, 5'd0);
        // R3 every rounding encoding
        for (int e = 0; e < 4; e++)
            step("R3 rounding write", 1'b1, e, 1'b0, 1'b0, 1'b0, 5'd0);
        // R4 denormal bit
        step("R4 denormal on", 1'b1, 32'h0004_0000, 1'b0, 1'b0, 1'b0, 5'd0);
        // R5/R7 enable overflow (bit 9), report overflow -> pulse
        step("R5 setup", 1'b1, 32'h0000_0201, 1'b0, 1'b0, 1'b0, 5'd0);
        step("R5 R6 overflow update", 1'b0, '0, 1'b1, 1'b0, 1'b0, 5'b00100);
        idle("R7 pulse ends");
        // R6 zero flags: cause kept, flags cleared, no request despite old cause & enable
        step("R6 zero-flag update", 1'b0, '0, 1'b1, 1'b0, 1'b0, 5'd0);
        // R6 non-matching flag: cause accumulates, still request since old cause matches
        step("R6 accumulate inexact", 1'b0, '0, 1'b1, 1'b0, 1'b0, 5'b00001);
        // R8 ordered compare leaves word alone
        step("R8 ordered compare", 1'b0, '0, 1'b0, 1'b1, 1'b0, 5'b10000);
        step("R8 unordered compare", 1'b0, '0, 1'b0, 1'b1, 1'b1, 5'b10000);
        // R9 collision
        step("R9 write beats op", 1'b1, 32'h0000_0F80, 1'b1, 1'b0, 1'b0, 5'b11111);
        // R10 controls kept across update
        step("R10 setup", 1'b1, 32'h0004_0F82, 1'b0, 1'b0, 1'b0, 5'd0);
        step("R10 update keeps controls", 1'b0, '0, 1'b1, 1'b0, 1'b0, 5'b01010);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            logic w, od, cd, cu;
            string tag;
            r  = $urandom;
            w  = ($urandom % 6) == 0;
            od = ($urandom % 2) == 0;
            cd = ($urandom % 4) == 0;
            cu = $urandom % 2;
            if (w && (od || (cd && cu))) tag = "R9 random collision";
            else if (w)                  tag = "R2 random write";
            else if (od)                 tag = "R5 random op";
            else if (cd)                 tag = "R8 random compare";
            else                         tag = "R10 random idle";
            step(tag, w, $urandom, od, cd, cu, r[4:0]);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=hung expected=finished");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule